// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a synthesizable behavioural model of a small synchronous static RAM with four-beat bursts. Each word holds four 9-bit byte lanes. On a rising clock edge, either of two address strobes captures a new external address. A 2-bit offset generator then walks the two low address bits through a four-beat burst. The burst order is either an upward wrap or an XOR pattern, chosen by a mode pin. An advance input steps the burst. While advance is high the current address is held for a wait cycle.

The two strobes have different roles. The processor strobe is gated by the first chip enable and always begins a read. The controller strobe begins a read or a write, according to the write controls, and it is also where the three chip enables select or deselect the device. On every cycle of a selected burst, the write controls decide which lanes of the current word take the input data. A global write covers all four lanes. A byte-write enable combined with per-lane strobes writes individual lanes. Read data comes out on a separate output bus, qualified by a drive-enable output. An asynchronous output enable gates that drive. A snooze input freezes the device: it accepts no cycles and keeps the array contents.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the device is deselected: `dq_oe_o` is 0 and `rdata_o` is all zeros.
- R2: An edge with `cpu_as_ni`=0 and `en_a_ni`=0 loads `addr_i`, with the offset counter at its first beat, and starts a read. No lane is written on that edge, whatever the write controls are.
- R3: An edge with `ctl_as_ni`=0 (and no accepted processor strobe) loads `addr_i`. If the device is selected and the write controls request a write, the word at `addr_i` is written on that same edge. On later selected edges, writes go to the current burst address.
- R4: The device is selected only when `en_a_ni`=0, `en_b_i`=1 and `en_c_ni`=0 at an accepted strobe edge. A deselected device drives nothing and writes nothing until the next accepted strobe. `cpu_as_ni` has no effect while `en_a_ni`=1.
- R5: With `interleave_i`=0, the low two address bits for burst beat k are (start+k) mod 4. Bits above bit 1 never change within a burst.
- R6: With `interleave_i`=1, the low two address bits for burst beat k are start XOR k.
- R7: An edge with `burst_adv_ni`=1 and no accepted strobe is a wait cycle. The address stays unchanged.
- R8: `wr_all_ni`=0 writes all four lanes, regardless of `wr_byte_ni` and `lane_wr_ni`.
- R9: With `wr_all_ni`=1 and `wr_byte_ni`=0, lane i (bits 9i+8 down to 9i) is written exactly when `lane_wr_ni[i]`=0. With both `wr_all_ni` and `wr_byte_ni` high, the cycle is a read.
- R10: `dq_oe_o` is 1 only when the device is selected, the last accepted cycle was a read, `out_en_ni`=0 and `snooze_i`=0. This enable responds to `out_en_ni` without a clock edge. When `dq_oe_o` is 0, `rdata_o` is all zeros.
- R11: While `snooze_i`=1, edges accept no strobe, no advance and no write. The burst state and the array contents are kept, and `dq_oe_o` is 0.
- R12: When both strobes are low on the same edge and `en_a_ni`=0, the processor strobe wins, so the cycle is a read with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe_o | output | 1 | Read data drive enable |
| cpu_as_ni | input | 1 | Processor address strobe, read-only start, active low |
| ctl_as_ni | input | 1 | Controller address strobe, active low |
| burst_adv_ni | input | 1 | Burst advance, active low; high means wait |
| en_a_ni | input | 1 | Chip enable, active low; also gates the processor strobe |
| en_b_i | input | 1 | Chip enable, active high |
| en_c_ni | input | 1 | Chip enable, active low |
| wr_all_ni | input | 1 | Global write of all lanes, active low |
| wr_byte_ni | input | 1 | Byte-write enable, active low |
| lane_wr_ni | input | LANES | Per-lane write strobes, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| interleave_i | input | 1 | Burst order: 0 upward wrap, 1 XOR |
| snooze_i | input | 1 | Standby freeze, active high |

## Verification
The hardest situation to reach is a burst that continues after an edge with no drive or no write. Examples are a wait cycle, a snooze freeze in mid-burst, and continuation edges after a deselecting controller strobe that still carry write controls. Only reading the array back afterwards shows whether anything leaked. The stimulus first fills every word with an address-derived pattern, using write bursts of both orders. It then drives those continuation edges with the global write held low, and afterwards reads the affected words through processor-strobe bursts. Any stray write, any step during a wait cycle, or any misordered beat appears as a pattern mismatch.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // low address offset for burst beat k from start offset s
  function automatic logic [1:0] burst_off(input logic [1:0] s, input logic [1:0] k,
                                           input logic xor_order);
    return xor_order ? (s ^ k) : (s + k);
  endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] start_i,
  input  logic       step_i,
  input  logic       mode_i,
  output logic [1:0] off_o,
  output logic [1:0] off_nxt_o
);
  logic [1:0] cnt_q, cnt_d, start_q, start_d;

  always_comb begin
    start_d = load_i ? start_i : start_q;
    if (load_i)      cnt_d = 2'd0;
    else if (step_i) cnt_d = cnt_q + 2'd1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= 2'd0;
      start_q <= 2'd0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign off_o     = burst_off(start_q, cnt_q, mode_i);
  assign off_nxt_o = burst_off(start_d, cnt_d, mode_i);

  // R5
  lin_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !mode_i) |=> (mode_i || off_o == $past(off_o) + 2'd1));
  // R6
  xor_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && mode_i) |=>
      (!mode_i || (off_o ^ $past(off_o)) == ($past(cnt_q) ^ ($past(cnt_q) + 2'd1))));
  // R7
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(cnt_q) && $stable(start_q)));
endmodule

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_all_ni,
  input  logic             wr_byte_ni,
  input  logic [LANES-1:0] lane_wr_ni,
  output logic [LANES-1:0] mask_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = !wr_all_ni || (!wr_byte_ni && !lane_wr_ni[i]);
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  lane_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && lane_i[i])
        mem[waddr_i][i*LANE_W +: LANE_W] <= wdata_i[i*LANE_W +: LANE_W];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int HI_W  = ADDR_W - 2,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              dq_oe_o,
  input  logic              cpu_as_ni,
  input  logic              ctl_as_ni,
  input  logic              burst_adv_ni,
  input  logic              en_a_ni,
  input  logic              en_b_i,
  input  logic              en_c_ni,
  input  logic              wr_all_ni,
  input  logic              wr_byte_ni,
  input  logic [LANES-1:0]  lane_wr_ni,
  input  logic              out_en_ni,
  input  logic              interleave_i,
  input  logic              snooze_i
);
  logic            take_p, take_c, load, step, sel_new, sel_d, sel_q, wr_q, wr_go, drive;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      off_q, off_nxt;
  logic [LANES-1:0] mask;
  logic [DW-1:0]   rd;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;

  // processor strobe outranks controller strobe
  assign take_p  = !snooze_i && !cpu_as_ni && !en_a_ni;
  assign take_c  = !snooze_i && !take_p && !ctl_as_ni;
  assign load    = take_p || take_c;
  assign sel_new = !en_a_ni && en_b_i && !en_c_ni;
  assign sel_d   = load ? sel_new : sel_q;
  assign hi_d    = load ? addr_i[ADDR_W-1:2] : hi_q;
  assign step    = !snooze_i && !load && sel_q && !burst_adv_ni;

  sbs_burst_ctr u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .start_i   (addr_i[1:0]),
    .step_i    (step),
    .mode_i    (interleave_i),
    .off_o     (off_q),
    .off_nxt_o (off_nxt)
  );

  sbs_wr_decode #(.LANES(LANES)) u_dec (
    .wr_all_ni  (wr_all_ni),
    .wr_byte_ni (wr_byte_ni),
    .lane_wr_ni (lane_wr_ni),
    .mask_o     (mask)
  );

  assign wr_go    = !snooze_i && !take_p && sel_d && (|mask);
  assign cur_addr = {hi_q, off_q};
  assign nxt_addr = {hi_d, off_nxt};

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_go),
    .lane_i  (mask),
    .waddr_i (nxt_addr),
    .wdata_i (wdata_i),
    .raddr_i (cur_addr),
    .rdata_o (rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      hi_q  <= '0;
    end else if (!snooze_i) begin
      sel_q <= sel_d;
      wr_q  <= wr_go;
      hi_q  <= hi_d;
    end
  end

  assign drive   = sel_q && !wr_q && !out_en_ni && !snooze_i;
  assign dq_oe_o = drive;
  assign rdata_o = drive ? rd : '0;

  // R11
  snooze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |=> ($stable(cur_addr) && $stable(sel_q)));
  // R10
  wr_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> !dq_oe_o);
endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic dq_oe;
  logic cpu_as_n = 1, ctl_as_n = 1, adv_n = 1, en_a_n = 0, en_b = 1, en_c_n = 0;
  logic wr_all_n = 1, wr_byte_n = 1, oe_n = 0, il = 0, snz = 0;
  logic [3:0] lane_n = 4'hF;

  int tests = 0, fails = 0;
  logic [DW-1:0] model [64];

  always #2.5 clk = ~clk;

  sync_burst_sram uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dq_oe_o(dq_oe), .cpu_as_ni(cpu_as_n), .ctl_as_ni(ctl_as_n), .burst_adv_ni(adv_n),
    .en_a_ni(en_a_n), .en_b_i(en_b), .en_c_ni(en_c_n), .wr_all_ni(wr_all_n),
    .wr_byte_ni(wr_byte_n), .lane_wr_ni(lane_n), .out_en_ni(oe_n),
    .interleave_i(il), .snooze_i(snz)
  );

  function automatic logic [DW-1:0] pat(int a);
    return 36'(a) * 36'h0_1234_5679 + 36'h5A5;
  endfunction

  function automatic int beat(int a, int k, bit x);
    int s = a & 3;
    return (a & ~3) | (x ? (s ^ k) : ((s + k) & 3));
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cpu_as_n = 1; ctl_as_n = 1; adv_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF;
    en_a_n = 0; en_b = 1; en_c_n = 0;
  endtask

  // R3 write burst: strobe edge writes start word, continuation edges write next beats
  task automatic wburst(int a, bit x);
    il = x;
    for (int k = 0; k < 4; k++) begin
      int wa = beat(a, k, x);
      ctl_as_n = (k == 0) ? 0 : 1;
      adv_n = (k == 0) ? 1 : 0;
      addr = AW'(a);
      wr_all_n = 0;
      wdata = pat(wa);
      tick();
      model[wa] = pat(wa);
      check("R10 write cycle no drive", 36'(dq_oe), 36'd0);
    end
    idle();
  endtask

  // R2 read burst: load edge carries global write low, which must be ignored
  task automatic rburst(int a, bit x, string req);
    il = x;
    for (int k = 0; k < 4; k++) begin
      int ra = beat(a, k, x);
      cpu_as_n = (k == 0) ? 0 : 1;
      wr_all_n = (k == 0) ? 0 : 1;
      adv_n = (k == 0) ? 1 : 0;
      addr = AW'(a);
      wdata = ~pat(ra);
      tick();
      check(req, rdata, model[ra]);
      check("R2 read drive", 36'(dq_oe), 36'd1);
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] e;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 reset oe", 36'(dq_oe), 36'd0);
    check("R1 reset data", rdata, 36'd0);
    rst_n = 1;
    tick();

    // fill all 64 words with bursts of both orders
    for (int u = 0; u < 16; u++) wburst(u * 4 + (u % 4), u[0]);
    // R5 R6 sweep: every start offset, both orders
    for (int x = 0; x < 2; x++)
      for (int s = 0; s < 4; s++)
        for (int u = 0; u < 16; u++)
          rburst(u * 4 + s, x[0], x == 0 ? "R5 linear beat" : "R6 xor beat");

    // R9 lane strobes over all 16 combinations at word 37
    for (int m = 0; m < 16; m++) begin
      ctl_as_n = 0; addr = 6'd37; wr_byte_n = 0; lane_n = 4'(m);
      wdata = {4{9'(m * 37 + 5)}};
      tick();
      for (int i = 0; i < 4; i++)
        if (!m[i]) model[37][i*9 +: 9] = wdata[i*9 +: 9];
      idle();
      rburst(37, 0, "R9 lane merge");
    end
    // R9 byte enable high, global high: read, no write
    ctl_as_n = 0; addr = 6'd37; wr_byte_n = 1; lane_n = 4'h0; wdata = '1;
    tick();
    check("R9 read cycle drive", 36'(dq_oe), 36'd1);
    check("R9 read cycle data", rdata, model[37]);
    idle();
    // R8 global write overrides disabled lanes
    ctl_as_n = 0; addr = 6'd37; wr_all_n = 0; wr_byte_n = 1; lane_n = 4'hF;
    wdata = 36'h1_2345_6789;
    tick();
    model[37] = 36'h1_2345_6789;
    idle();
    rburst(37, 0, "R8 global write");
    ctl_as_n = 0; addr = 6'd37; wr_all_n = 0; wr_byte_n = 0; lane_n = 4'hA;
    wdata = 36'hF_EDCB_A987;
    tick();
    model[37] = 36'hF_EDCB_A987;
    idle();
    rburst(37, 0, "R8 global over byte");

    // R7 wait cycles at start offset 2, then no carry into upper bits (R5)
    il = 0; cpu_as_n = 0; addr = 6'd22;
    tick();
    idle();
    check("R7 first beat", rdata, model[22]);
    tick(); check("R7 wait 1", rdata, model[22]);
    tick(); check("R7 wait 2", rdata, model[22]);
    adv_n = 0;
    tick(); check("R7 step after wait", rdata, model[23]);
    tick(); check("R5 wrap no carry", rdata, model[20]);
    idle();

    // R10 asynchronous output enable, no clock edge
    oe_n = 1; #1;
    check("R10 oe off", 36'(dq_oe), 36'd0);
    check("R10 oe off data", rdata, 36'd0);
    oe_n = 0; #1;
    check("R10 oe on", rdata, model[20]);

    // R11 snooze mid-burst: strobe, advance and write all refused
    snz = 1; #1;
    check("R11 snooze no drive", 36'(dq_oe), 36'd0);
    ctl_as_n = 0; addr = 6'd50; adv_n = 0; wr_all_n = 0; wdata = '0;
    tick(); tick();
    check("R11 snooze no drive", 36'(dq_oe), 36'd0);
    idle();
    snz = 0; #1;
    check("R11 state held", rdata, model[20]);
    rburst(50, 0, "R11 array kept");
    rburst(20, 0, "R11 array kept");

    // R4 deselect via controller strobe with chip enable b low
    ctl_as_n = 0; en_b = 0; addr = 6'd9; wr_all_n = 0; wdata = '0;
    tick();
    check("R4 deselect no drive", 36'(dq_oe), 36'd0);
    ctl_as_n = 1; en_b = 1; adv_n = 0;
    tick(); tick();
    check("R4 deselect continuation", 36'(dq_oe), 36'd0);
    // processor strobe gated off by chip enable a
    idle(); cpu_as_n = 0; en_a_n = 1; addr = 6'd9;
    tick();
    check("R4 gated strobe ignored", 36'(dq_oe), 36'd0);
    idle();
    rburst(9, 0, "R4 no write when deselected");
    rburst(10, 0, "R4 no write when deselected");
    // controller strobe with chip enable c high
    ctl_as_n = 0; en_c_n = 1; addr = 6'd11; wr_all_n = 0; wdata = '0;
    tick();
    check("R4 en_c deselect", 36'(dq_oe), 36'd0);
    idle();
    rburst(11, 0, "R4 no write when deselected");

    // R12 both strobes with global write low: processor strobe read wins
    cpu_as_n = 0; ctl_as_n = 0; addr = 6'd44; wr_all_n = 0; wdata = '0;
    tick();
    e = model[44];
    check("R12 read wins drive", 36'(dq_oe), 36'd1);
    check("R12 read wins data", rdata, e);
    idle();
    rburst(44, 0, "R12 no write");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule